// File: doc/BRIEF.md
# Direct-Mapped Read Cache with Line Refill and Replay

This block is a read-only, direct-mapped cache that holds 16 KB of 32-bit words in 256 lines of 16 words each. One request port takes a 32-bit byte address. The same lookup logic serves instruction fetches and data loads. One cycle after a request is accepted, the block reports whether the address hit. On a hit it also returns the addressed word.

When a lookup misses, the cache asks a memory port for the whole line, starting at the line-aligned address. It stores the returned words in order. Once the sixteenth word is stored, it marks the line valid with its new tag and runs the original lookup again, and that replayed lookup hits.

The request port uses a valid/ready handshake. A request transfers on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high when the block is idle and in the cycle a lookup hits, so hits can follow each other on consecutive cycles. It falls for the whole of a miss. The refill request uses the same rule: `mem_req_valid` and `mem_req_addr` stay steady until `mem_req_ready` is seen. Refill data has no back-pressure and is accepted whenever `mem_rsp_valid` is high. Response pins are plain outputs.

Top module: `dm_refill_cache`

## Requirements
- R1: After reset every line is invalid: `req_ready`=1, `rsp_valid`=0, `mem_req_valid`=0, and the first lookup of any address misses.
- R2: Address fields are byte address bits [5:2] word offset, [13:6] line index, [31:14] tag. Bits [1:0] have no effect on hit or data.
- R3: A request accepted on an edge gives `rsp_valid`=1 in the following cycle. During a hit, `req_ready` stays 1, so back-to-back requests are served one per cycle.
- R4: On a hit, `rsp_hit`=1 and `rsp_data` is word [5:2] of the line holding the address.
- R5: After a miss response, `mem_req_valid` rises in the next cycle with `mem_req_addr` equal to the request address with bits [5:0] cleared. Both are held until `mem_req_ready` is seen.
- R6: Refill words are accepted on cycles with `mem_rsp_valid`=1 and are stored at word offsets 0 to 15 in arrival order. Gaps between words are allowed.
- R7: No hit is reported while the line is being refilled. One cycle after the edge that accepts the sixteenth word, the replayed lookup gives `rsp_valid`=1 and `rsp_hit`=1.
- R8: `req_ready` is 0 from the miss response cycle until the replay response cycle.
- R9: Two addresses with the same index but different tags evict each other, so each miss replaces the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup request can be taken |
| req_addr | input | 32 | Byte address of the request |
| rsp_valid | output | 1 | Lookup result present this cycle |
| rsp_hit | output | 1 | Lookup found the word |
| rsp_data | output | 32 | Word returned on a hit |
| mem_req_valid | output | 1 | Line refill request |
| mem_req_ready | input | 1 | Memory takes the refill request |
| mem_req_addr | output | 32 | Line-aligned refill byte address |
| mem_rsp_valid | input | 1 | Refill word present |
| mem_rsp_data | input | 32 | Refill word |

## Verification
The lookup result is due one cycle after the accepting edge, and the refill request one cycle after the miss response. The replay result is due one cycle after the edge that takes the sixteenth refill word. The bench drives inputs on falling edges and samples outputs on the very next falling edge, so each check lands in exactly the cycle the requirement names. A bench model of the tags and of memory contents predicts hit or miss and the data for every lookup. Random delays on `mem_req_ready` and random gaps between refill words move those due cycles around, and the bench tracks them.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_MREQ = 2'd2,
    ST_FILL = 2'd3
  } dmc_state_e;
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
  parameter int LINES = 256,
  parameter int TAG_W = 18,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_valid,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag
);
  logic [TAG_W-1:0] tag_q [LINES];
  logic [LINES-1:0] valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) valid_q <= '0;
    else if (wr_en) valid_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_idx] <= wr_tag;
  end

  assign rd_tag   = tag_q[rd_idx];
  assign rd_valid = valid_q[rd_idx];

  // R7: a tag write leaves the line valid and holding the written tag
  p_tag_written_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (valid_q[$past(wr_idx)] && tag_q[$past(wr_idx)] == $past(wr_tag)));
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
  parameter int LINES      = 256,
  parameter int LINE_WORDS = 16,
  parameter int WORD_W     = 32,
  localparam int IDX_W = $clog2(LINES),
  localparam int OFF_W = $clog2(LINE_WORDS)
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [WORD_W-1:0] rd_word,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [WORD_W-1:0] wr_word
);
  logic [WORD_W-1:0] mem_q [LINES][LINE_WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_idx][wr_off] <= wr_word;
  end

  assign rd_word = mem_q[rd_idx][rd_off];
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
#(
  parameter int WA_W       = 30,
  parameter int LINE_WORDS = 16,
  localparam int OFF_W = $clog2(LINE_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [WA_W-1:0]  req_waddr,
  output logic             req_ready,
  input  logic             hit,
  output logic             look,
  output logic [WA_W-1:0]  pend_waddr,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [WA_W-1:0]  mem_req_waddr,
  input  logic             mem_rsp_valid,
  output logic             fill_we,
  output logic [OFF_W-1:0] fill_off,
  output logic             fill_last
);
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(LINE_WORDS - 1);

  dmc_state_e       state_q, state_d;
  logic [WA_W-1:0]  pend_q;
  logic [OFF_W-1:0] cnt_q;
  logic             accept;

  assign look      = (state_q == ST_LOOK);
  assign req_ready = (state_q == ST_IDLE) || (look && hit);
  assign accept    = req_valid && req_ready;
  assign fill_we   = (state_q == ST_FILL) && mem_rsp_valid;
  assign fill_off  = cnt_q;
  assign fill_last = fill_we && (cnt_q == LAST_OFF);

  assign pend_waddr    = pend_q;
  assign mem_req_valid = (state_q == ST_MREQ);
  assign mem_req_waddr = {pend_q[WA_W-1:OFF_W], {OFF_W{1'b0}}};

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = ST_LOOK;
      ST_LOOK: if (!hit) state_d = ST_MREQ;
               else if (!accept) state_d = ST_IDLE;
      ST_MREQ: if (mem_req_ready) state_d = ST_FILL;
      ST_FILL: if (fill_last) state_d = ST_LOOK;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      pend_q  <= '0;
    end else begin
      state_q <= state_d;
      if (accept) pend_q <= req_waddr;
      if (state_q == ST_MREQ) cnt_q <= '0;
      else if (fill_we) cnt_q <= cnt_q + 1'b1;
    end
  end

  // R5: refill request stays up and steady until memory takes it
  p_mreq_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_waddr)));
  // R8: no new request is taken while a refill is outstanding
  p_ready_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid || state_q == ST_FILL) |-> !req_ready);
  // R6: refill words are counted up from offset zero
  p_fill_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |=> (cnt_q == '0));
endmodule

// File: rtl/dm_refill_cache.sv
module dm_refill_cache #(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 16,
  parameter int LINES      = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [WORD_W-1:0] rsp_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_data
);
  localparam int BYTE_W = $clog2(WORD_W / 8);
  localparam int WA_W   = ADDR_W - BYTE_W;
  localparam int OFF_W  = $clog2(LINE_WORDS);
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = WA_W - OFF_W - IDX_W;

  logic [WA_W-1:0]  pend_waddr, mem_waddr;
  logic [OFF_W-1:0] fill_off;
  logic [TAG_W-1:0] rd_tag;
  logic             rd_valid, hit, look, fill_we, fill_last;
  logic             unused_byte_bits;

  assign unused_byte_bits = ^req_addr[BYTE_W-1:0];

  wire [OFF_W-1:0] p_off = pend_waddr[OFF_W-1:0];
  wire [IDX_W-1:0] p_idx = pend_waddr[OFF_W +: IDX_W];
  wire [TAG_W-1:0] p_tag = pend_waddr[WA_W-1 -: TAG_W];

  assign hit       = rd_valid && (rd_tag == p_tag);
  assign rsp_valid = look;
  assign rsp_hit   = look && hit;
  assign mem_req_addr = {mem_waddr, {BYTE_W{1'b0}}};

  dmc_ctrl #(.WA_W(WA_W), .LINE_WORDS(LINE_WORDS)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_waddr(req_addr[ADDR_W-1:BYTE_W]), .req_ready(req_ready),
    .hit(hit), .look(look), .pend_waddr(pend_waddr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_waddr(mem_waddr),
    .mem_rsp_valid(mem_rsp_valid),
    .fill_we(fill_we), .fill_off(fill_off), .fill_last(fill_last)
  );

  dmc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) tags_i (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(p_idx), .rd_tag(rd_tag), .rd_valid(rd_valid),
    .wr_en(fill_last), .wr_idx(p_idx), .wr_tag(p_tag)
  );

  dmc_data_store #(.LINES(LINES), .LINE_WORDS(LINE_WORDS), .WORD_W(WORD_W)) data_i (
    .clk(clk),
    .rd_idx(p_idx), .rd_off(p_off), .rd_word(rsp_data),
    .wr_en(fill_we), .wr_idx(p_idx), .wr_off(fill_off), .wr_word(mem_rsp_data)
  );

  // R3: an accepted request is answered in the next cycle
  p_resp_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);
  // R7: the replayed lookup after the last refill word hits
  p_replay_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_last |=> (rsp_valid && rsp_hit));
  // R5: refill address is line aligned
  p_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[OFF_W+BYTE_W-1:0] == '0));
  // R7: nothing hits while a line is being filled
  p_no_partial_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_we |-> !rsp_hit);
endmodule

// File: tb/dm_refill_cache_tb_top.sv
`timescale 1ns/1ps
module dm_refill_cache_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [31:0] req_addr = '0, mem_rsp_data = '0;
  logic        req_ready, rsp_valid, rsp_hit, mem_req_valid;
  logic [31:0] rsp_data, mem_req_addr;

  int checks = 0, errors = 0;
  bit done = 0;
  bit        mv [256];
  bit [17:0] mt [256];

  always #2.5 clk = ~clk;

  dm_refill_cache dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return ({2'b00, a[31:2]} * 32'h9E37_79B1) ^ 32'hC3A5_0F1E;
  endfunction

  function automatic bit model_hit(input logic [31:0] a);
    return mv[a[13:6]] && (mt[a[13:6]] == a[31:14]);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic refill(input logic [31:0] a);
    logic [31:0] base;
    base = {a[31:6], 6'b0};
    @(negedge clk);
    chk(mem_req_valid == 1'b1, "R5 req", {31'b0, mem_req_valid}, 32'd1);
    chk(mem_req_addr == base, "R5 addr", mem_req_addr, base);
    repeat ($urandom_range(0, 2)) begin
      @(negedge clk);
      chk(mem_req_valid && mem_req_addr == base, "R5 hold", mem_req_addr, base);
    end
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    for (int w = 0; w < 16; w++) begin
      repeat ($urandom_range(0, 2)) begin
        @(negedge clk);
        chk(!rsp_valid && !req_ready, "R7/R8 gap", {30'b0, rsp_valid, req_ready}, 32'd0);
      end
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = mem_word(base + 32'(4 * w));
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (w < 15) chk(!rsp_hit && !req_ready, "R7 partial", {30'b0, rsp_hit, req_ready}, 32'd0);
    end
    mv[a[13:6]] = 1'b1;
    mt[a[13:6]] = a[31:14];
    chk(rsp_valid && rsp_hit, "R7 replay", {30'b0, rsp_valid, rsp_hit}, 32'd3);
    chk(rsp_data == mem_word(a), "R6 replay data", rsp_data, mem_word(a));
    chk(req_ready == 1'b1, "R8 ready back", {31'b0, req_ready}, 32'd1);
  endtask

  task automatic do_req(input logic [31:0] a, input string tag);
    bit eh;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    chk(req_ready == 1'b1, "R8 idle ready", {31'b0, req_ready}, 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    eh = model_hit(a);
    chk(rsp_valid == 1'b1, "R3 rsp", {31'b0, rsp_valid}, 32'd1);
    chk(rsp_hit == eh, tag, {31'b0, rsp_hit}, {31'b0, eh});
    if (eh) chk(rsp_data == mem_word(a), "R4 data", rsp_data, mem_word(a));
    else begin
      chk(req_ready == 1'b0, "R8 miss", {31'b0, req_ready}, 32'd0);
      refill(a);
    end
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    checks++;
    errors++;
    finish_run();
  end

  initial begin
    logic [31:0] a;
    void'($urandom(32'd12345));
    foreach (mv[i]) mv[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_req_valid, "R1 reset",
        {29'b0, req_ready, rsp_valid, mem_req_valid}, 32'd4);
    do_req(32'h0000_1234, "R1 cold miss");
    do_req(32'h0000_1234, "R4 rehit");
    do_req(32'h0000_1237, "R2 byte ignored");
    do_req(32'h0000_1200, "R4 other word");
    do_req(32'h0000_123C, "R4 last word");
    do_req(32'hFFFF_FFFC, "R2 top miss");
    do_req(32'hFFFF_FFC1, "R2 top hit");
    // R9: same index, different tags
    do_req(32'h0000_4148, "R9 first");
    do_req(32'h0000_8148, "R9 conflict");
    do_req(32'h0000_4148, "R9 evicted");
    // R3: back-to-back hits on one line
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = 32'h0000_4140;
    @(negedge clk);
    chk(rsp_hit && rsp_data == mem_word(32'h0000_4140), "R3 b2b first", rsp_data, mem_word(32'h0000_4140));
    chk(req_ready == 1'b1, "R3 ready in hit", {31'b0, req_ready}, 32'd1);
    req_addr = 32'h0000_417C;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid && rsp_hit && rsp_data == mem_word(32'h0000_417C), "R3 b2b second",
        rsp_data, mem_word(32'h0000_417C));
    // random mix
    for (int n = 0; n < 300; n++) begin
      a = {$urandom_range(0, 3) == 0 ? 18'($urandom) : 18'($urandom_range(0, 2)),
           ($urandom_range(0, 1) == 0) ? 8'($urandom) : 8'($urandom_range(0, 5)),
           4'($urandom), 2'($urandom)};
      do_req(a, "R4/R9 random");
    end
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule